// File: doc/BRIEF.md
# Host-to-Controller Mailbox Registers

This block is a small memory-mapped mailbox between a host processor and a controller processor. The host talks to it over a plain register bus that carries an address, a write strobe with write data, and a read strobe. Read data comes back one cycle after the read strobe. To send a request, the host first fills a four-word outbound buffer. It then writes a packed command word. Accepting that word latches the opcode, sub-command, data size and completion-interrupt request, sets a busy flag, and sends a one-cycle doorbell to the controller.

The controller reads the latched command fields and the outbound buffer directly from dedicated ports. When it has finished, it raises a single-cycle done strobe. In that same cycle it presents an error flag, an 8-bit error code and four words of inbound data. The block clears busy and captures the results. If the command asked for a completion interrupt, the block also sends the host a one-cycle interrupt pulse and sets a sticky interrupt flag. The host clears that flag by writing a one to it. While busy is set, the block rejects a second command, so a request in flight cannot be overwritten.

Top module: `mbox_regs`

## Requirements
- R1: Reset clears busy, error, error code, the interrupt flag and both buffers. After reset, the status word reads as the initiator id (default 0x01) in bits [15:8] with every other bit zero, and every inbound word reads zero.
- R2: A write to offset 0x00 while idle is accepted. It latches the command fields: bits [7:0] opcode, bit 8 completion-interrupt request, bits [15:12] sub-command, bits [23:16] size. From the next cycle, busy reads 1, and ctl_doorbell is high for exactly that one cycle.
- R3: A write to offset 0x00 while busy is ignored. No doorbell is raised, and the latched command fields do not change.
- R4: Word i of the outbound buffer is written at offset 0x80+4i and appears on ctl_obuf bits [32i+31:32i]. Reads of offset 0x00 and of the outbound range return zero.
- R5: A done strobe while busy clears busy and captures the error flag, the error code and the inbound data. Inbound word i then reads at offset 0x90+4i. A done strobe while idle changes nothing.
- R6: If the completing command had bit 8 set, host_irq is high for exactly one cycle, in the cycle after done, and status bit 2 becomes 1. If bit 8 was clear, neither happens.
- R7: Writing status (offset 0x04) with bit 2 set clears the interrupt flag. Writing status with bit 2 clear changes nothing, and no other status bit can be written.
- R8: Status layout: bit 0 busy, bit 1 error, bit 2 interrupt flag, bit 3 zero, bits [7:4] latched sub-command, bits [15:8] initiator id, bits [23:16] error code, bits [31:24] zero.
- R9: Accepting a new command clears the error flag and the error code.
- R10: h_rdata is registered. It holds the value addressed by a read in the cycle after h_rd was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_addr | input | ADDR_W | Host byte address |
| h_wr | input | 1 | Host write strobe |
| h_wdata | input | 32 | Host write data |
| h_rd | input | 1 | Host read strobe |
| h_rdata | output | 32 | Host read data, one cycle after h_rd |
| host_irq | output | 1 | One-cycle completion interrupt to the host |
| ctl_doorbell | output | 1 | One-cycle pulse: new command accepted |
| ctl_opcode | output | 8 | Latched opcode |
| ctl_sub | output | 4 | Latched sub-command |
| ctl_size | output | 8 | Latched data size |
| ctl_irq_req | output | 1 | Latched completion-interrupt request |
| ctl_obuf | output | 32*BUF_WORDS | Outbound buffer contents |
| ctl_done | input | 1 | Controller completion strobe |
| ctl_err | input | 1 | Error flag, valid with ctl_done |
| ctl_err_code | input | 8 | Error code, valid with ctl_done |
| ctl_ibuf | input | 32*BUF_WORDS | Inbound data, valid with ctl_done |

## Verification
The command path is exercised with three kinds of command:
- A command with the interrupt request set and a clean completion.
- A command without the interrupt request that completes with an error. Comparing it with the first case shows whether the pulse and the sticky flag follow bit 8, and whether the error fields follow the done inputs.
- A third command issued right after the failed one, which shows whether acceptance clears the stale error.

Two further patterns expose a block that reacts to events it should drop: a second command written while busy, and a done strobe with new data arriving while idle. Reset is also applied in the middle of a busy command, which shows whether reset reaches every piece of state.

// File: rtl/mbox_pkg.sv
// Shared definitions for the mailbox register block: the fixed register
// offsets, the layout of the command word and the read-mux select codes.
// Assumes a 32-bit host data path.
package mbox_pkg;

    localparam int OFF_CMD  = 'h00;
    localparam int OFF_STAT = 'h04;
    localparam int OFF_OBUF = 'h80;
    localparam int OFF_IBUF = 'h90;

    localparam int STAT_IRQ_BIT = 2;

    // Command fields kept after acceptance
    typedef struct packed {
        logic [7:0] size;
        logic [3:0] sub;
        logic       irq_req;
        logic [7:0] opcode;
    } mbox_cmd_t;

    typedef enum logic [1:0] {
        RSEL_ZERO = 2'd0,
        RSEL_STAT = 2'd1,
        RSEL_IBUF = 2'd2
    } rsel_e;

    // Pull the meaningful fields out of a host command word
    function automatic mbox_cmd_t unpack_cmd(input logic [31:0] w);
        mbox_cmd_t c;
        c.opcode  = w[7:0];
        c.irq_req = w[8];
        c.sub     = w[15:12];
        c.size    = w[23:16];
        return c;
    endfunction

endpackage

// File: rtl/mbox_decode.sv
// Address decoder for the host side of the mailbox.
// Turns the host address and write strobe into per-register write enables,
// and selects the source for the read mux. Assumes BUF_WORDS*4 bytes fit
// between each buffer base and the next region; the low two address bits
// are not used to select a word.
module mbox_decode
    import mbox_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int BUF_WORDS = 4,
    parameter int IDX_W     = 2
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    output logic                 cmd_we,
    output logic                 stat_we,
    output logic [BUF_WORDS-1:0] obuf_we,
    output rsel_e                rsel,
    output logic [IDX_W-1:0]     ridx
);

    localparam int BUF_BYTES = BUF_WORDS * 4;
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFF_CMD);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
    localparam logic [ADDR_W-1:0] A_OBUF = ADDR_W'(OFF_OBUF);
    localparam logic [ADDR_W-1:0] A_IBUF = ADDR_W'(OFF_IBUF);
    localparam logic [ADDR_W-1:0] A_OEND = ADDR_W'(OFF_OBUF + BUF_BYTES);
    localparam logic [ADDR_W-1:0] A_IEND = ADDR_W'(OFF_IBUF + BUF_BYTES);

    logic             hit_cmd;
    logic             hit_stat;
    logic             in_obuf;
    logic             in_ibuf;
    logic [IDX_W-1:0] obuf_idx;

    // Region hits and word indices
    always_comb begin
        hit_cmd  = (addr >> 2) == (A_CMD >> 2);
        hit_stat = (addr >> 2) == (A_STAT >> 2);
        in_obuf  = (addr >= A_OBUF) && (addr < A_OEND);
        in_ibuf  = (addr >= A_IBUF) && (addr < A_IEND);
        obuf_idx = IDX_W'((addr - A_OBUF) >> 2);
        ridx     = IDX_W'((addr - A_IBUF) >> 2);
    end

    assign cmd_we  = wr && hit_cmd;
    assign stat_we = wr && hit_stat;

    // One write enable per outbound word
    for (genvar i = 0; i < BUF_WORDS; i++) begin : g_owe
        assign obuf_we[i] = wr && in_obuf && (obuf_idx == IDX_W'(i));
    end

    // Read source: status, inbound buffer, or zero for everything else
    always_comb begin
        if (in_ibuf)       rsel = RSEL_IBUF;
        else if (hit_stat) rsel = RSEL_STAT;
        else               rsel = RSEL_ZERO;
    end

endmodule

// File: rtl/mbox_wordbuf.sv
// Word buffer of WORDS entries of W bits each.
// A word can be written on its own through we[i], or all words can be
// loaded at once through load. Load wins when both happen in one cycle.
// Reset clears every word.
module mbox_wordbuf #(
    parameter int W     = 32,
    parameter int WORDS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [WORDS-1:0]   we,
    input  logic [W-1:0]       wdata,
    input  logic               load,
    input  logic [WORDS*W-1:0] ldata,
    output logic [WORDS*W-1:0] q
);

    for (genvar i = 0; i < WORDS; i++) begin : g_word
        logic [W-1:0] word_q;

        // Holds word i: cleared by reset, loaded in bulk, or written alone
        always_ff @(posedge clk) begin
            if (!rst_n)     word_q <= '0;
            else if (load)  word_q <= ldata[i*W +: W];
            else if (we[i]) word_q <= wdata;
        end

        assign q[i*W +: W] = word_q;
    end

endmodule

// File: rtl/mbox_ctrl.sv
// Command and status control for the mailbox.
// Accepts a command only while idle, holds busy until the controller
// reports done, records the error result, and produces the completion
// interrupt pulse and its sticky flag. Assumes ctl_done is a one-cycle
// strobe; a strobe while idle is dropped.
module mbox_ctrl
    import mbox_pkg::*;
#(
    parameter logic [7:0] INIT_ID = 8'h01
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  mbox_cmd_t   cmd_in,
    input  logic        irq_clr,
    input  logic        ctl_done,
    input  logic        ctl_err,
    input  logic [7:0]  ctl_err_code,
    output mbox_cmd_t   cmd_q,
    output logic        busy,
    output logic        doorbell,
    output logic        irq_flag,
    output logic        host_irq,
    output logic        ibuf_load,
    output logic [31:0] status
);

    logic       accept;
    logic       finish;
    logic       err_q;
    logic [7:0] code_q;

    assign accept    = cmd_we && !busy;
    assign finish    = ctl_done && busy;
    assign ibuf_load = finish;

    // Latch the command fields on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (accept) cmd_q <= cmd_in;
    end

    // Busy: set on acceptance, cleared on completion
    always_ff @(posedge clk) begin
        if (!rst_n)      busy <= 1'b0;
        else if (accept) busy <= 1'b1;
        else if (finish) busy <= 1'b0;
    end

    // One-cycle doorbell toward the controller
    always_ff @(posedge clk) begin
        if (!rst_n) doorbell <= 1'b0;
        else        doorbell <= accept;
    end

    // Error result: cleared on a new command, captured on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q  <= 1'b0;
            code_q <= '0;
        end else if (accept) begin
            err_q  <= 1'b0;
            code_q <= '0;
        end else if (finish) begin
            err_q  <= ctl_err;
            code_q <= ctl_err_code;
        end
    end

    // Sticky interrupt flag: a new completion wins over a host clear
    always_ff @(posedge clk) begin
        if (!rst_n)                         irq_flag <= 1'b0;
        else if (finish && cmd_q.irq_req)   irq_flag <= 1'b1;
        else if (irq_clr)                   irq_flag <= 1'b0;
    end

    // Edge-type completion pulse toward the host
    always_ff @(posedge clk) begin
        if (!rst_n) host_irq <= 1'b0;
        else        host_irq <= finish && cmd_q.irq_req;
    end

    assign status = {8'h00, code_q, INIT_ID, cmd_q.sub, 1'b0, irq_flag, err_q, busy};

endmodule

// File: rtl/mbox_regs.sv
// Top of the mailbox register block.
// Ties together the host decoder, the outbound and inbound word buffers,
// and command/status control, and registers the host read data.
// Assumes a 32-bit host bus and at most four words per buffer, so each
// buffer fits its 16-byte window.
module mbox_regs
    import mbox_pkg::*;
#(
    parameter int         ADDR_W    = 8,
    parameter int         BUF_WORDS = 4,
    parameter logic [7:0] INIT_ID   = 8'h01
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       h_addr,
    input  logic                    h_wr,
    input  logic [31:0]             h_wdata,
    input  logic                    h_rd,
    output logic [31:0]             h_rdata,
    output logic                    host_irq,
    output logic                    ctl_doorbell,
    output logic [7:0]              ctl_opcode,
    output logic [3:0]              ctl_sub,
    output logic [7:0]              ctl_size,
    output logic                    ctl_irq_req,
    output logic [32*BUF_WORDS-1:0] ctl_obuf,
    input  logic                    ctl_done,
    input  logic                    ctl_err,
    input  logic [7:0]              ctl_err_code,
    input  logic [32*BUF_WORDS-1:0] ctl_ibuf
);

    localparam int IDX_W = (BUF_WORDS > 1) ? $clog2(BUF_WORDS) : 1;
    localparam int BUF_W = 32 * BUF_WORDS;

    logic                 cmd_we;
    logic                 stat_we;
    logic [BUF_WORDS-1:0] obuf_we;
    rsel_e                rsel;
    logic [IDX_W-1:0]     ridx;
    mbox_cmd_t            cmd_in;
    mbox_cmd_t            cmd_q;
    logic                 busy;
    logic                 irq_flag;
    logic                 ibuf_load;
    logic                 irq_clr;
    logic [31:0]          status;
    logic [BUF_W-1:0]     ibuf_q;

    assign cmd_in  = unpack_cmd(h_wdata);
    assign irq_clr = stat_we && h_wdata[STAT_IRQ_BIT];

    mbox_decode #(
        .ADDR_W    (ADDR_W),
        .BUF_WORDS (BUF_WORDS),
        .IDX_W     (IDX_W)
    ) u_dec (
        .addr    (h_addr),
        .wr      (h_wr),
        .cmd_we  (cmd_we),
        .stat_we (stat_we),
        .obuf_we (obuf_we),
        .rsel    (rsel),
        .ridx    (ridx)
    );

    mbox_wordbuf #(
        .W     (32),
        .WORDS (BUF_WORDS)
    ) u_obuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (obuf_we),
        .wdata (h_wdata),
        .load  (1'b0),
        .ldata ({BUF_W{1'b0}}),
        .q     (ctl_obuf)
    );

    mbox_wordbuf #(
        .W     (32),
        .WORDS (BUF_WORDS)
    ) u_ibuf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    ({BUF_WORDS{1'b0}}),
        .wdata (32'h0),
        .load  (ibuf_load),
        .ldata (ctl_ibuf),
        .q     (ibuf_q)
    );

    mbox_ctrl #(
        .INIT_ID (INIT_ID)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_we       (cmd_we),
        .cmd_in       (cmd_in),
        .irq_clr      (irq_clr),
        .ctl_done     (ctl_done),
        .ctl_err      (ctl_err),
        .ctl_err_code (ctl_err_code),
        .cmd_q        (cmd_q),
        .busy         (busy),
        .doorbell     (ctl_doorbell),
        .irq_flag     (irq_flag),
        .host_irq     (host_irq),
        .ibuf_load    (ibuf_load),
        .status       (status)
    );

    assign ctl_opcode  = cmd_q.opcode;
    assign ctl_sub     = cmd_q.sub;
    assign ctl_size    = cmd_q.size;
    assign ctl_irq_req = cmd_q.irq_req;

    // Registered read mux; the value is held between reads
    always_ff @(posedge clk) begin
        if (!rst_n) h_rdata <= '0;
        else if (h_rd) begin
            case (rsel)
                RSEL_STAT: h_rdata <= status;
                RSEL_IBUF: h_rdata <= ibuf_q[ridx*32 +: 32];
                default:   h_rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/mbox_regs_chk.sv
// Property checker for mbox_regs, bound into every instance.
// It observes the host command writes, the controller strobes, and the
// internal busy and interrupt-flag state.
module mbox_regs_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] h_addr,
    input logic              h_wr,
    input logic              ctl_doorbell,
    input logic [7:0]        ctl_opcode,
    input logic              ctl_done,
    input logic              ctl_irq_req,
    input logic              host_irq,
    input logic              busy,
    input logic              irq_flag
);

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (!busy && !irq_flag));

    p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && (h_addr == '0) && !busy) |=> (ctl_doorbell && busy));

    p_doorbell_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_doorbell |=> !ctl_doorbell);

    p_ignore_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && (h_addr == '0) && busy) |=> (!ctl_doorbell && $stable(ctl_opcode)));

    p_done_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_done && busy) |=> !busy);

    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> $past(ctl_done && busy && ctl_irq_req));

    p_irq_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq |-> irq_flag);

endmodule

bind mbox_regs mbox_regs_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_mbox_regs.sv
// Scoreboard bench for mbox_regs. The read driver pushes an expected word
// into a queue; the monitor pops and compares it when the registered
// read data arrives.
module sim_mbox_regs;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   h_addr = '0;
    logic         h_wr = 1'b0;
    logic [31:0]  h_wdata = '0;
    logic         h_rd = 1'b0;
    logic [31:0]  h_rdata;
    logic         host_irq;
    logic         ctl_doorbell;
    logic [7:0]   ctl_opcode;
    logic [3:0]   ctl_sub;
    logic [7:0]   ctl_size;
    logic         ctl_irq_req;
    logic [127:0] ctl_obuf;
    logic         ctl_done = 1'b0;
    logic         ctl_err = 1'b0;
    logic [7:0]   ctl_err_code = '0;
    logic [127:0] ctl_ibuf = '0;

    int n_cmp = 0;
    int n_bad = 0;
    int db_cnt = 0;
    int irq_cnt = 0;
    logic rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    mbox_regs u0 (.*);

    function automatic logic [31:0] stat(input logic b, input logic e, input logic i,
                                         input logic [3:0] s, input logic [7:0] c);
        return {8'h00, c, 8'h01, s, 1'b0, i, e, b};
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        h_addr = a; h_wdata = d; h_wr = 1'b1;
        @(negedge clk);
        h_wr = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        h_addr = a; h_rd = 1'b1;
        @(negedge clk);
        h_rd = 1'b0;
    endtask

    task automatic ctl_finish(input logic e, input logic [7:0] c, input logic [127:0] d);
        @(negedge clk);
        ctl_done = 1'b1; ctl_err = e; ctl_err_code = c; ctl_ibuf = d;
        @(negedge clk);
        ctl_done = 1'b0; ctl_err = 1'b0; ctl_err_code = '0; ctl_ibuf = '0;
    endtask

    // Pulse counters, sampling the value held during the previous cycle
    always @(posedge clk) begin
        rd_seen <= h_rd;
        if (ctl_doorbell) db_cnt++;
        if (host_irq) irq_cnt++;
    end

    // Monitor: compare read data one cycle after each read strobe (R10)
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            chk(tag_q.pop_front(), {96'h0, h_rdata}, {96'h0, exp_q.pop_front()});
        end
    end

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    localparam logic [127:0] IDATA = 128'hD3D2D1D0_C3C2C1C0_B3B2B1B0_A3A2A1A0;
    localparam logic [127:0] ODATA = 128'h44444444_33333333_22222222_11111111;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        host_read(8'h04, stat(0, 0, 0, 4'h0, 8'h00), "R1 status after reset");
        host_read(8'h90, 32'h0, "R1 inbound word0 after reset");
        chk("R1 obuf after reset", ctl_obuf, 128'h0);

        // R4 outbound buffer
        for (int i = 0; i < 4; i++) host_write(8'(8'h80 + 4 * i), ODATA[32*i +: 32]);
        chk("R4 ctl_obuf contents", ctl_obuf, ODATA);
        host_read(8'h84, 32'h0, "R4 outbound read returns zero");
        host_read(8'h00, 32'h0, "R4 command read returns zero");

        // R2 accepted command: size 3, sub 2, irq request, opcode FF
        host_write(8'h00, 32'h0003_21FF);
        @(negedge clk);
        chk("R2 doorbell count", 128'(db_cnt), 128'd1);
        chk("R2 latched fields", {ctl_size, ctl_sub, ctl_irq_req, ctl_opcode},
            {8'h03, 4'h2, 1'b1, 8'hFF});
        host_read(8'h04, stat(1, 0, 0, 4'h2, 8'h00), "R2 R8 status busy");

        // R3 command while busy
        host_write(8'h00, 32'h0005_3042);
        @(negedge clk);
        chk("R3 no extra doorbell", 128'(db_cnt), 128'd1);
        chk("R3 fields unchanged", {ctl_size, ctl_sub, ctl_irq_req, ctl_opcode},
            {8'h03, 4'h2, 1'b1, 8'hFF});

        // R5 R6 completion with interrupt request
        ctl_finish(1'b0, 8'h00, IDATA);
        @(negedge clk);
        chk("R6 one host_irq pulse", 128'(irq_cnt), 128'd1);
        host_read(8'h04, stat(0, 0, 1, 4'h2, 8'h00), "R5 R6 status after done");
        for (int i = 0; i < 4; i++)
            host_read(8'(8'h90 + 4 * i), IDATA[32*i +: 32], "R5 inbound word");

        // R7 interrupt flag clear
        host_write(8'h04, 32'hFFFF_FFFB);
        host_read(8'h04, stat(0, 0, 1, 4'h2, 8'h00), "R7 write without bit2 ignored");
        host_write(8'h04, 32'h0000_0004);
        host_read(8'h04, stat(0, 0, 0, 4'h2, 8'h00), "R7 bit2 clears flag");

        // R5 done while idle is dropped
        ctl_finish(1'b1, 8'h77, ~IDATA);
        host_read(8'h04, stat(0, 0, 0, 4'h2, 8'h00), "R5 idle done status unchanged");
        host_read(8'h98, IDATA[64 +: 32], "R5 idle done data unchanged");

        // R6 R8 command without interrupt request, completing with error
        host_write(8'h00, 32'h0001_7010);
        ctl_finish(1'b1, 8'hE5, 128'h5);
        @(negedge clk);
        chk("R6 no pulse without bit8", 128'(irq_cnt), 128'd1);
        host_read(8'h04, stat(0, 1, 0, 4'h7, 8'hE5), "R8 error status");

        // R9 acceptance clears error
        host_write(8'h00, 32'h0000_9120);
        host_read(8'h04, stat(1, 0, 0, 4'h9, 8'h00), "R9 error cleared on accept");
        chk("R2 second accepted doorbell", 128'(db_cnt), 128'd3);

        // R1 reset while busy
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        host_read(8'h04, stat(0, 0, 0, 4'h0, 8'h00), "R1 status after mid-command reset");
        host_read(8'h90, 32'h0, "R1 inbound cleared by reset");
        chk("R1 obuf cleared by reset", ctl_obuf, 128'h0);

        repeat (3) @(negedge clk);
        chk("R10 all reads answered", 128'(exp_q.size()), 128'd0);
        finish_run();
    end

endmodule